// File: doc/BRIEF.md
# Multiplexed-Address Dynamic RAM Controller with Row-Only Refresh

This block sits between a simple host request port and a one-bit-wide dynamic RAM that holds 2^(2·ROW_BITS) cells behind a ROW_BITS-wide multiplexed address bus and two active-low strobes. The host presents a full address with a read or write. The controller puts the low half of that address on the pins and drops the row strobe. It then swaps the upper half onto the same pins and drops the column strobe. Only after both halves are latched does it drive the write enable, or sample the returned bit for a read. A read ends with a one-cycle valid pulse.

Stored charge leaks away, so an internal timer adds one row of refresh debt every REF_INTERVAL clock cycles. With a 50 MHz clock and 1024 rows, the default of 97 cycles keeps every row inside a 2 ms window. Refresh pulses only the row strobe and keeps the column strobe high, so the RAM output stays disconnected. A free-running row pointer steps through every row and wraps. The REF_BURST parameter chooses how refresh is grouped. With REF_BURST = 1, single rows slip in between host accesses. With a larger value, refresh waits until that much debt has built up and then clears all of it back to back. Owed refresh takes priority over a new host request, but it never breaks into an access that has already started.

Top module: `dram_ctrl`

## Requirements
- R1: The row (host address bits [ROW_BITS-1:0]) is on the pins in the cycle before the row strobe falls and stays unchanged across the fall.
- R2: The column (host address bits [2·ROW_BITS-1:ROW_BITS]) is on the pins in the cycle before the column strobe falls and stays unchanged across the fall. The column strobe is low only while the row strobe is low.
- R3: The write enable (active low) goes low only for a host write, only while both strobes are low, and carries the request's data bit. A read raises rd_valid for exactly one cycle, in the cycle the row strobe returns high. rd_data is then the bit last written to that address, or 0 if the address was never written. rd_valid is low in every other cycle.
- R4: A host access holds the row strobe low for exactly 4 cycles without a break, and the column strobe falls inside that window.
- R5: ready is high only when no access is in progress, the row strobe is high and the precharge wait has expired. A request is taken on a clock edge where req_valid and ready are both high, and only one request is outstanding at a time.
- R6: During refresh, the column strobe and the write enable stay high, the row strobe is low for T_REF_LOW cycles, and the pins carry the refresh row. Refresh rows start at 0 after reset, rise by one with each pulse and wrap from 2^ROW_BITS-1 to 0.
- R7: Refresh debt increases by one at every REF_INTERVAL-th clock edge after reset, counting the first edge with reset released as edge 1. Each refresh pulse reduces it by one.
- R8: A refresh pulse starts only when the debt is nonzero. A run of pulses starts only when the debt has reached REF_BURST, and it then continues until the debt is zero.
- R9: While refresh is due (debt at least REF_BURST, or a run still unfinished), ready stays low. An access already under way is never cut short.
- R10: Between any two row-strobe low periods, the row strobe is high for at least T_PRECHARGE cycles.
- R11: During reset, all strobes and the write enable are high and rd_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2·ROW_BITS | Cell address: low half is row, high half is column |
| req_wdata | input | 1 | Data bit for a write |
| ready | output | 1 | Controller can take a request this cycle |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 1 | Read data bit |
| dram_addr | output | ROW_BITS | Multiplexed address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_wdata | output | 1 | Data bit to the RAM |
| dram_rdata | input | 1 | Data bit from the RAM |

## Verification
Two functions can fall in the same cycle: a timer tick that makes refresh due, and a host request arriving when ready is high or an access that is mid-flight. The bench keeps requests back to back for tens of thousands of cycles, with a short refresh interval and a burst size of 4, so ticks land at every phase of an access. In each cycle the bench compares ready against a debt figure it derives on its own from elapsed edges minus the refresh pulses it has seen. Each host access must keep its 4-cycle strobe window and return correct data. Each refresh pulse must start only under the debt rule and carry the next row in order.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RSET = 3'd1,
        ST_RSTB = 3'd2,
        ST_CSET = 3'd3,
        ST_CSTB = 3'd4,
        ST_XFER = 3'd5,
        ST_FSET = 3'd6,
        ST_FSTB = 3'd7
    } state_e;

    typedef enum logic [1:0] {
        SEL_ROW = 2'd0,
        SEL_COL = 2'd1,
        SEL_REF = 2'd2
    } addr_sel_e;

endpackage

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
    parameter int REF_INTERVAL = 97,
    parameter int REF_BURST    = 1,
    parameter int OWED_W       = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    output logic due
);
    localparam int TW = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1;
    localparam logic [TW-1:0]     TLAST = TW'(REF_INTERVAL - 1);
    localparam logic [OWED_W-1:0] BURST = OWED_W'(REF_BURST);

    typedef struct packed {
        logic [TW-1:0]     tcnt;
        logic [OWED_W-1:0] owed;
        logic              burst;
    } sched_t;

    sched_t s_q, s_d;
    logic   tick;

    always_comb begin
        s_d  = s_q;
        tick = (s_q.tcnt == TLAST);
        s_d.tcnt = tick ? '0 : s_q.tcnt + 1'b1;
        case ({tick, take})
            2'b10:   s_d.owed = s_q.owed + 1'b1;
            2'b01:   s_d.owed = s_q.owed - 1'b1;
            default: s_d.owed = s_q.owed;
        endcase
        if (take) s_d.burst = (s_d.owed != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign due = (s_q.owed >= BURST) || (s_q.burst && (s_q.owed != '0));

    // R8
    take_with_debt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (s_q.owed != '0));

    // R7
    debt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.owed != '1);

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
    import dram_ctrl_pkg::*;
#(
    parameter int ROW_BITS = 10
) (
    input  addr_sel_e               sel,
    input  logic [2*ROW_BITS-1:0]   host_addr,
    input  logic [ROW_BITS-1:0]     ref_row,
    output logic [ROW_BITS-1:0]     pin_addr
);
    always_comb begin
        case (sel)
            SEL_COL: pin_addr = host_addr[2*ROW_BITS-1:ROW_BITS];
            SEL_REF: pin_addr = ref_row;
            default: pin_addr = host_addr[ROW_BITS-1:0];
        endcase
    end
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl
    import dram_ctrl_pkg::*;
#(
    parameter int ROW_BITS     = 10,
    parameter int REF_INTERVAL = 97,
    parameter int REF_BURST    = 1,
    parameter int T_PRECHARGE  = 3,
    parameter int T_REF_LOW    = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [2*ROW_BITS-1:0]   req_addr,
    input  logic                    req_wdata,
    output logic                    ready,
    output logic                    rd_valid,
    output logic                    rd_data,
    output logic [ROW_BITS-1:0]     dram_addr,
    output logic                    dram_ras_n,
    output logic                    dram_cas_n,
    output logic                    dram_we_n,
    output logic                    dram_wdata,
    input  logic                    dram_rdata
);
    localparam int ADDR_BITS = 2 * ROW_BITS;
    localparam int WAIT_MAX  = (T_PRECHARGE > T_REF_LOW) ? T_PRECHARGE : T_REF_LOW;
    localparam int CNT_W     = $clog2(WAIT_MAX + 1);
    localparam int OWED_W    = $clog2(REF_BURST + 3) + 1;
    localparam logic [CNT_W-1:0] PRE_LOAD = CNT_W'(T_PRECHARGE - 1);
    localparam logic [CNT_W-1:0] REF_LOAD = CNT_W'(T_REF_LOW - 1);

    typedef struct packed {
        state_e                 st;
        logic [CNT_W-1:0]       cnt;
        logic [ADDR_BITS-1:0]   addr;
        logic                   wr;
        logic                   wdat;
        logic [ROW_BITS-1:0]    ref_row;
        logic                   rdv;
        logic                   rdd;
    } ctl_t;

    ctl_t      c_q, c_d;
    logic      due;
    logic      take;
    addr_sel_e sel;

    dram_refresh_sched #(
        .REF_INTERVAL (REF_INTERVAL),
        .REF_BURST    (REF_BURST),
        .OWED_W       (OWED_W)
    ) u_sched (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take),
        .due   (due)
    );

    always_comb begin
        c_d     = c_q;
        c_d.rdv = 1'b0;
        take    = 1'b0;
        case (c_q.st)
            ST_IDLE: begin
                if (c_q.cnt != '0) begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end else if (due) begin
                    c_d.st = ST_FSET;
                end else if (req_valid) begin
                    c_d.st   = ST_RSET;
                    c_d.addr = req_addr;
                    c_d.wr   = req_write;
                    c_d.wdat = req_wdata;
                end
            end
            ST_RSET: c_d.st = ST_RSTB;
            ST_RSTB: c_d.st = ST_CSET;
            ST_CSET: c_d.st = ST_CSTB;
            ST_CSTB: c_d.st = ST_XFER;
            ST_XFER: begin
                c_d.st  = ST_IDLE;
                c_d.cnt = PRE_LOAD;
                c_d.rdv = !c_q.wr;
                if (!c_q.wr) c_d.rdd = dram_rdata;
            end
            ST_FSET: begin
                c_d.st  = ST_FSTB;
                c_d.cnt = REF_LOAD;
                take    = 1'b1;
            end
            ST_FSTB: begin
                if (c_q.cnt != '0) begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end else begin
                    c_d.st      = ST_IDLE;
                    c_d.cnt     = PRE_LOAD;
                    c_d.ref_row = c_q.ref_row + 1'b1;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    always_comb begin
        case (c_q.st)
            ST_CSET, ST_CSTB, ST_XFER: sel = SEL_COL;
            ST_FSET, ST_FSTB:          sel = SEL_REF;
            default:                   sel = SEL_ROW;
        endcase
    end

    dram_addr_mux #(.ROW_BITS(ROW_BITS)) u_mux (
        .sel       (sel),
        .host_addr (c_q.addr),
        .ref_row   (c_q.ref_row),
        .pin_addr  (dram_addr)
    );

    assign dram_ras_n = !(c_q.st inside {ST_RSTB, ST_CSET, ST_CSTB, ST_XFER, ST_FSTB});
    assign dram_cas_n = !(c_q.st inside {ST_CSTB, ST_XFER});
    assign dram_we_n  = !((c_q.st == ST_XFER) && c_q.wr);
    assign dram_wdata = c_q.wdat;
    assign ready      = (c_q.st == ST_IDLE) && (c_q.cnt == '0) && !due;
    assign rd_valid   = c_q.rdv;
    assign rd_data    = c_q.rdd;

    // R1
    row_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> $stable(dram_addr));

    // R2
    col_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> ($stable(dram_addr) && !dram_ras_n));

    // R2
    cas_under_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);

    // R3
    we_after_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> (!dram_cas_n && $past(!dram_cas_n)));

    // R3
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R5
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (dram_ras_n && dram_cas_n));

    // R10
    precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |=> dram_ras_n);

endmodule

// File: tb/dram_ctrl_test.sv
`timescale 1ns/1ps
module dram_ctrl_test;
    localparam int P_ROW   = 10;
    localparam int P_INT   = 20;
    localparam int P_BURST = 4;
    localparam int P_TRP   = 3;
    localparam int P_RLOW  = 2;
    localparam int NROWS   = 1 << P_ROW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_wdata = 1'b0;
    logic [2*P_ROW-1:0] req_addr = '0;
    logic ready, rd_valid, rd_data;
    logic [P_ROW-1:0] dram_addr;
    logic dram_ras_n, dram_cas_n, dram_we_n, dram_wdata;
    logic stub_dout = 1'b0;

    always #10 clk = ~clk;

    dram_ctrl #(
        .ROW_BITS(P_ROW), .REF_INTERVAL(P_INT), .REF_BURST(P_BURST),
        .T_PRECHARGE(P_TRP), .T_REF_LOW(P_RLOW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_wdata(dram_wdata), .dram_rdata(stub_dout)
    );

    int  n_chk = 0, n_fail = 0;
    bit  finished = 0;
    int  edges = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) if (rst_n) edges++;

    // behavioural state of the reference
    bit  shadow [int];
    bit  stub   [int];
    bit  p_ras = 1, p_cas = 1;
    int  p_addr = 0;
    int  high_cnt = 1000, low_cnt = 0;
    bit  host_pend = 0, host_act = 0, ref_act = 0, cas_seen = 0;
    bit  exp_wr = 0, exp_d = 0, exp_rd = 0;
    int  exp_addr = 0, exp_ref = 0, started = 0, owed = 0, ticks = 0;
    bit  in_burst = 0;
    int  lat_row = 0, lat_col = 0, reads_done = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            chk(dram_ras_n && dram_cas_n && dram_we_n, "R11 strobes high in reset",
                {dram_ras_n, dram_cas_n, dram_we_n}, 7);
            chk(!rd_valid, "R11 rd_valid low in reset", rd_valid, 0);
        end else begin
            ticks = edges / P_INT;
            owed  = ticks - started;
            // row strobe falling
            if (!dram_ras_n && p_ras) begin
                chk(int'(dram_addr) == p_addr, "R1 address held across row strobe fall",
                    dram_addr, p_addr);
                chk(high_cnt >= P_TRP, "R10 precharge high time", high_cnt, P_TRP);
                low_cnt = 0;
                if (host_pend && !host_act) begin
                    host_act = 1; cas_seen = 0;
                    lat_row  = dram_addr;
                    chk(int'(dram_addr) == (exp_addr % NROWS), "R1 row half on pins",
                        dram_addr, exp_addr % NROWS);
                end else begin
                    chk(owed >= 1, "R8 refresh only with debt", owed, 1);
                    chk(owed >= P_BURST || in_burst, "R8 run starts at burst size", owed, P_BURST);
                    ref_act = 1;
                    started++;
                    owed = ticks - started;
                    in_burst = (owed != 0);
                    chk(int'(dram_addr) == exp_ref, "R6 refresh row order", dram_addr, exp_ref);
                    exp_ref = (exp_ref + 1) % NROWS;
                end
            end
            // row strobe rising
            if (dram_ras_n && !p_ras) begin
                if (host_act) begin
                    chk(low_cnt == 4, "R4 access strobe window", low_cnt, 4);
                    chk(cas_seen, "R4 column strobe inside window", cas_seen, 1);
                    if (!exp_wr) begin
                        chk(rd_valid == 1'b1, "R3 rd_valid pulse", rd_valid, 1);
                        chk(rd_data == exp_rd, "R3 read data", rd_data, exp_rd);
                        reads_done++;
                    end else begin
                        chk(!rd_valid, "R3 no rd_valid after write", rd_valid, 0);
                    end
                    host_act = 0; host_pend = 0;
                end else if (ref_act) begin
                    chk(low_cnt == P_RLOW, "R6 refresh low time", low_cnt, P_RLOW);
                    ref_act = 0;
                end
                high_cnt = 0;
            end else begin
                chk(!rd_valid, "R3 rd_valid only at access end", rd_valid, 0);
            end
            if (!dram_ras_n) low_cnt++;
            else             high_cnt++;
            chk(!(!dram_cas_n && dram_ras_n), "R2 column strobe only under row strobe",
                dram_cas_n, 1);
            if (ref_act)
                chk(dram_cas_n && dram_we_n, "R6 refresh keeps column strobe and we high",
                    {dram_cas_n, dram_we_n}, 3);
            if (!dram_cas_n && p_cas) begin
                cas_seen = 1;
                chk(int'(dram_addr) == p_addr, "R2 address held across column strobe fall",
                    dram_addr, p_addr);
                chk(int'(dram_addr) == (exp_addr / NROWS), "R2 column half on pins",
                    dram_addr, exp_addr / NROWS);
                lat_col   = dram_addr;
                stub_dout = stub.exists(lat_col * NROWS + lat_row) ? stub[lat_col * NROWS + lat_row] : 1'b0;
            end
            if (!dram_we_n) begin
                chk(host_act && exp_wr && !dram_cas_n && !p_cas, "R3 write enable only for write after strobes",
                    {host_act, exp_wr}, 3);
                chk(dram_wdata == exp_d, "R3 write data bit", dram_wdata, exp_d);
                stub[lat_col * NROWS + lat_row] = dram_wdata;
            end
            chk(owed >= 0 && owed <= P_BURST + 1, "R7 refresh debt bounded", owed, P_BURST);
            if (ready) begin
                chk(!host_pend && dram_ras_n, "R5 ready only when idle", host_pend, 0);
                chk(owed < P_BURST && !(in_burst && owed > 0), "R9 refresh due blocks ready",
                    owed, P_BURST - 1);
                if (req_valid) begin
                    host_pend = 1;
                    exp_addr  = int'(req_addr);
                    exp_wr    = req_write;
                    exp_d     = req_wdata;
                    if (req_write) shadow[exp_addr] = req_wdata;
                    else exp_rd = shadow.exists(exp_addr) ? shadow[exp_addr] : 1'b0;
                end
            end
        end
        p_ras  = dram_ras_n;
        p_cas  = dram_cas_n;
        p_addr = dram_addr;
    end

    task automatic do_req(input bit wr, input int a, input bit d);
        @(posedge clk); #2;
        while (!ready) begin @(posedge clk); #2; end
        req_valid = 1'b1; req_write = wr; req_addr = a[2*P_ROW-1:0]; req_wdata = d;
        @(posedge clk); #2;
        req_valid = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", edges, 0);
        summary();
    end

    initial begin
        int unsigned lf;
        int a, b;
        lf = 32'h1234_5678;
        repeat (4) @(posedge clk);
        #3 rst_n = 1'b1;
        // corner addresses: row all-ones / column zero, and the reverse
        do_req(1, 32'h003FF, 1);
        do_req(1, 32'hFFC00, 1);
        do_req(1, 32'h00000, 0);
        do_req(0, 32'h003FF, 0);
        do_req(0, 32'hFFC00, 0);
        do_req(0, 32'h00000, 0);
        do_req(0, 32'h55AAA, 0);
        do_req(1, 32'h003FF, 0);
        do_req(0, 32'h003FF, 0);
        for (int i = 0; i < 2200; i++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            a = int'(lf & 32'hFFFFF);
            b = int'((lf >> 7) & 32'hFFFFF);
            do_req(1, a, lf[31]);
            do_req(0, a, 0);
            do_req(0, b, 0);
        end
        repeat (60) @(posedge clk);
        chk(started >= NROWS + 8, "R6 refresh row pointer wrapped", started, NROWS + 8);
        chk(reads_done >= 4400, "R3 all reads returned", reads_done, 4400);
        chk(!host_pend, "R5 no request left outstanding", host_pend, 0);
        summary();
    end
endmodule